// File: doc/BRIEF.md
# SPI Receive Word Packer

This block sits behind the sampling stage of an SPI controller. Each time the serial clock logic marks a sampling point, it takes one data bit, assembles eight such bits into a byte, and gathers four bytes into a 32-bit word. Each finished word goes into a small receive queue. The bus side drains that queue one word per read strobe.

A configuration input selects the byte lane order. With one setting, the first byte of a word appears in the top lane. With the other setting, it appears in the bottom lane. This lets software choose whether serial data lands in memory in stream order on its own processor. The bus data port is read-only. A write attempt against it is reported as an error and leaves the queue unchanged. The queue raises sticky flags for lost words (overflow) and for reads of an empty queue (underflow).

Top module: `spi_rx_word_packer`

## Requirements
- R1: Within each byte, the bit taken on the first `bit_strobe` becomes bit 7 of that byte, and the bit on the eighth strobe becomes bit 0.
- R2: With `lane_order` = 0, the first byte of a word lands in `rd_data[31:24]`, the second in `[23:16]`, the third in `[15:8]` and the fourth in `[7:0]`.
- R3: With `lane_order` = 1, the first byte of a word lands in `rd_data[7:0]`, and later bytes fill `[15:8]`, `[23:16]` and `[31:24]` in turn.
- R4: The value of `lane_order` in the cycle in which a word's first byte completes applies to that whole word. A change partway through a word takes effect from the next word.
- R5: A word enters the queue only on the clock edge that completes its fourth byte. `level` counts the stored words (0 to DEPTH). `empty` is 1 exactly when `level` is 0, and `full` is 1 exactly when `level` equals DEPTH.
- R6: Each `rd_req` cycle removes exactly one word, in arrival order. That word appears on `rd_data` from the following cycle and is held until the next read.
- R7: An `rd_req` while the queue is empty sets `rd_data` to zero in the following cycle. It also sets the sticky `underflow` flag and leaves `level` at 0.
- R8: A word completed while the queue is full is discarded, and the sticky `overflow` flag is set. The stored words and `level` are unchanged.
- R9: A `wr_req` pulse produces a one-cycle `wr_err` pulse in the following cycle. It changes neither `level` nor the stored words.
- R10: A low `rst_n` sampled at a clock edge empties the queue, discards any partial byte or word, and clears `rd_data`, `wr_err`, `overflow` and `underflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_strobe | input | 1 | Marks a cycle in which `bit_in` is a valid sample |
| bit_in | input | 1 | Sampled serial data bit |
| lane_order | input | 1 | 0: first byte in top lane; 1: first byte in bottom lane |
| rd_req | input | 1 | Bus read of the data port; pops one word |
| wr_req | input | 1 | Bus write attempt to the read-only data port |
| rd_data | output | 32 | Word popped by the most recent read |
| wr_err | output | 1 | Error response for a write attempt |
| level | output | $clog2(DEPTH)+1 | Number of words held in the queue |
| full | output | 1 | Queue holds DEPTH words |
| empty | output | 1 | Queue holds no words |
| overflow | output | 1 | Sticky: a completed word was dropped |
| underflow | output | 1 | Sticky: an empty queue was read |

## Verification
The bench sends the same byte sequence in both lane orders and uses bytes such as 0x80 and 0x01, so a reversed bit or lane order changes the result. It flips `lane_order` after the first byte of a word: a design that sampled the setting per byte would mix the two orders inside one word. It checks `level` after three bytes and after four, which catches a word pushed one byte early. It fills the queue, completes one extra word and drains the queue: a design that overwrote the oldest entry or let the pointers wrap would return the wrong first word. It also reads the empty queue, makes a write attempt while a word is stored, and applies reset partway through a byte, each checked against the output values that should follow.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
    parameter int BYTE_W  = 8;
    parameter int LANES   = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int BIT_CW = $clog2(BYTE_W);
    localparam int LANE_W = $clog2(LANES);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/spi_rx_bit_shifter.sv
module spi_rx_bit_shifter
    import spi_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  strobe_i,
    input  logic  bit_i,
    output logic  byte_valid_o,
    output byte_t byte_o
);
    typedef struct packed {
        logic [BYTE_W-2:0] shreg;
        logic [BIT_CW-1:0] cnt;
    } shift_st_t;

    shift_st_t st_q, st_d;
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

    always_comb begin
        st_d         = st_q;
        byte_valid_o = 1'b0;
        byte_o       = {st_q.shreg, bit_i};
        if (strobe_i) begin
            st_d.shreg = {st_q.shreg[BYTE_W-3:0], bit_i};
            st_d.cnt   = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_BIT) begin
                byte_valid_o = 1'b1;
                st_d.cnt     = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: a completed byte restarts the bit count
    a_r1_byte_restart: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |=> st_q.cnt == '0);
endmodule

// File: rtl/spi_rx_word_assembler.sv
module spi_rx_word_assembler
    import spi_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  byte_valid_i,
    input  byte_t byte_i,
    input  logic  lane_order_i,
    output logic  push_o,
    output word_t push_word_o
);
    typedef struct packed {
        word_t             word;
        logic [LANE_W-1:0] idx;
        logic              order;
    } asm_st_t;

    asm_st_t st_q, st_d;
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    logic              eff_order;
    logic [LANE_W-1:0] lane;

    always_comb begin
        st_d      = st_q;
        push_o    = 1'b0;
        eff_order = (st_q.idx == '0) ? lane_order_i : st_q.order;
        lane      = eff_order ? st_q.idx : (LAST_LANE - st_q.idx);
        if (byte_valid_i) begin
            st_d.order = eff_order;
            for (int l = 0; l < LANES; l++) begin
                if (lane == LANE_W'(l)) st_d.word[l*BYTE_W +: BYTE_W] = byte_i;
            end
            st_d.idx = st_q.idx + 1'b1;
            push_o   = (st_q.idx == LAST_LANE);
        end
        push_word_o = st_d.word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: after a push the next byte starts a new word
    a_r5_word_restart: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> st_q.idx == '0);
    // R4: lane order is frozen within a word
    a_r4_order_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.idx != '0) |=> $stable(st_q.order));
endmodule

// File: rtl/spi_rx_word_fifo.sv
module spi_rx_word_fifo
    import spi_rx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  word_t            push_word_i,
    input  logic             pop_i,
    output word_t            rdata_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             overflow_o,
    output logic             underflow_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    rptr;
        logic [CNT_W-1:0] count;
        word_t            rdata;
        logic             ovf;
        logic             unf;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    word_t    mem [DEPTH];
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        full_o  = (st_q.count == FULL_CNT);
        empty_o = (st_q.count == '0);
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (push_i && full_o) st_d.ovf = 1'b1;
        if (pop_i) begin
            if (empty_o) begin
                st_d.rdata = '0;
                st_d.unf   = 1'b1;
            end else begin
                st_d.rdata = mem[st_q.rptr];
                st_d.rptr  = st_q.rptr + 1'b1;
            end
        end
        if (do_push) st_d.wptr = st_q.wptr + 1'b1;
        st_d.count = st_q.count + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wptr] <= push_word_i;
    end

    assign rdata_o     = st_q.rdata;
    assign count_o     = st_q.count;
    assign overflow_o  = st_q.ovf;
    assign underflow_o = st_q.unf;

    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= FULL_CNT);
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);
    a_r8_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && full_o && !pop_i |=> count_o == FULL_CNT);
    a_r7_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && empty_o |=> rdata_o == '0 && underflow_o);
    a_r6_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && !empty_o && !push_i |=> count_o == $past(count_o) - 1'b1);
endmodule

// File: rtl/spi_rx_word_packer.sv
module spi_rx_word_packer
    import spi_rx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_strobe,
    input  logic             bit_in,
    input  logic             lane_order,
    input  logic             rd_req,
    input  logic             wr_req,
    output logic [31:0]      rd_data,
    output logic             wr_err,
    output logic [CNT_W-1:0] level,
    output logic             full,
    output logic             empty,
    output logic             overflow,
    output logic             underflow
);
    typedef struct packed {
        logic wr_err;
    } top_st_t;

    top_st_t st_q, st_d;
    logic    byte_valid, push;
    byte_t   byte_data;
    word_t   push_word, fifo_rdata;

    spi_rx_bit_shifter u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_i     (bit_strobe),
        .bit_i        (bit_in),
        .byte_valid_o (byte_valid),
        .byte_o       (byte_data)
    );

    spi_rx_word_assembler u_asm (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid_i (byte_valid),
        .byte_i       (byte_data),
        .lane_order_i (lane_order),
        .push_o       (push),
        .push_word_o  (push_word)
    );

    spi_rx_word_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_word_i (push_word),
        .pop_i       (rd_req),
        .rdata_o     (fifo_rdata),
        .count_o     (level),
        .full_o      (full),
        .empty_o     (empty),
        .overflow_o  (overflow),
        .underflow_o (underflow)
    );

    always_comb begin
        st_d        = st_q;
        st_d.wr_err = wr_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_err  = st_q.wr_err;
    assign rd_data = 32'(fifo_rdata);

    a_r9_write_error: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> wr_err);
    a_r9_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !rd_req && !push |=> $stable(level));
endmodule

// File: tb/spi_rx_word_packer_bench.sv
module spi_rx_word_packer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_strobe = 1'b0, bit_in = 1'b0, lane_order = 1'b0;
    logic        rd_req = 1'b0, wr_req = 1'b0;
    logic [31:0] rd_data;
    logic        wr_err, full, empty, overflow, underflow;
    logic [3:0]  level;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    spi_rx_word_packer u_spi_rx_word_packer (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .bit_in(bit_in),
        .lane_order(lane_order), .rd_req(rd_req), .wr_req(wr_req),
        .rd_data(rd_data), .wr_err(wr_err), .level(level), .full(full),
        .empty(empty), .overflow(overflow), .underflow(underflow)
    );

    // {lane_order, byte0, byte1, byte2, byte3, expected word}
    localparam logic [64:0] VEC [4] = '{
        {1'b0, 32'hA1B2C3D4, 32'hA1B2C3D4},
        {1'b1, 32'hA1B2C3D4, 32'hD4C3B2A1},
        {1'b0, 32'h00FF8001, 32'h00FF8001},
        {1'b1, 32'h12345678, 32'h78563412}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            bit_strobe = 1'b1;
            bit_in     = b[i];
        end
        @(negedge clk);
        bit_strobe = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] bytes);
        for (int k = 3; k >= 0; k--) send_byte(bytes[k*8 +: 8]);
    endtask

    task automatic pop_word();
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_strobe = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        check("R10 level", 32'(level), 0);
        check("R10 empty/full", {30'd0, empty, full}, 32'd2);
        check("R10 flags", {29'd0, overflow, underflow, wr_err}, 0);
        check("R10 rd_data", rd_data, 0);

        // R1 R2 R3 R6: vector table
        foreach (VEC[v]) begin
            lane_order = VEC[v][64];
            send_word(VEC[v][63:32]);
            check("R5 level after word", 32'(level), 1);
            pop_word();
            check($sformatf("R1/R2/R3 vector %0d", v), rd_data, VEC[v][31:0]);
            check("R6 level after pop", 32'(level), 0);
        end

        // R4: order changes mid-word
        lane_order = 1'b0;
        send_byte(8'h11);
        lane_order = 1'b1;
        send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
        send_word(32'h55667788);
        pop_word();
        check("R4 mid-word change ignored", rd_data, 32'h11223344);
        pop_word();
        check("R4 next word uses new order", rd_data, 32'h88776655);

        // R5: push only after fourth byte
        lane_order = 1'b0;
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
        check("R5 three bytes no push", 32'(level), 0);
        send_byte(8'h04);
        check("R5 fourth byte pushes", 32'(level), 1);
        pop_word();
        check("R6 popped word", rd_data, 32'h01020304);

        // R5 R8: fill, overflow, drain
        for (int w = 0; w < 8; w++)
            send_word({8'h10 + 8'(w), 8'h20 + 8'(w), 8'h30 + 8'(w), 8'h40 + 8'(w)});
        check("R5 full level", 32'(level), 8);
        check("R5 full flag", {31'd0, full}, 1);
        check("R8 no overflow yet", {31'd0, overflow}, 0);
        send_word(32'hEEEEEEEE);
        check("R8 overflow set", {31'd0, overflow}, 1);
        check("R8 level kept", 32'(level), 8);
        for (int w = 0; w < 8; w++) begin
            pop_word();
            check($sformatf("R6/R8 drain %0d", w), rd_data,
                  {8'h10 + 8'(w), 8'h20 + 8'(w), 8'h30 + 8'(w), 8'h40 + 8'(w)});
        end
        check("R5 empty after drain", {31'd0, empty}, 1);
        check("R8 overflow sticky", {31'd0, overflow}, 1);

        // R7: read while empty
        check("R7 underflow clear before", {31'd0, underflow}, 0);
        pop_word();
        check("R7 zero data", rd_data, 0);
        check("R7 underflow set", {31'd0, underflow}, 1);
        check("R7 level stays", 32'(level), 0);

        // R9: write attempt
        send_word(32'hA5A55A5A);
        @(negedge clk);
        wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        check("R9 wr_err pulse", {31'd0, wr_err}, 1);
        check("R9 level unchanged", 32'(level), 1);
        @(negedge clk);
        check("R9 wr_err one cycle", {31'd0, wr_err}, 0);
        pop_word();
        check("R9 word unchanged", rd_data, 32'hA5A55A5A);

        // R10: reset mid-byte discards partial data
        send_byte(8'hC0);
        @(negedge clk);
        bit_strobe = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        bit_strobe = 1'b1; bit_in = 1'b0;
        do_reset();
        check("R10 flags cleared", {30'd0, overflow, underflow}, 0);
        check("R10 rd_data cleared", rd_data, 0);
        send_word(32'h0A0B0C0D);
        pop_word();
        check("R10 partial discarded", rd_data, 32'h0A0B0C0D);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule